// File: doc/BRIEF.md
# Configurable Four-Lane Multiply-Add Slice

This block is an arithmetic slice for filter and correlator datapaths. It has four signed multipliers, each with a data operand register and a coefficient operand register. The products go through an optional pipeline register into a two-level adder tree: two pairwise sums, then their total. An output stage then presents one of three things, chosen by the operating mode:

- the total (sum mode);
- nothing from the adders (independent mode, where only the separate products are used);
- a running accumulation of successive totals (accumulate mode).

Each operand bank is set on its own to load in parallel from its own lane or to shift as a tap delay line. In a shifting bank the first register takes a serial input, each later register takes its neighbour, and the last register drives a cascade output so that slices can be chained. Because the two banks are set separately, data can stream serially through the taps while new coefficient sets are loaded in parallel in a single cycle.

The mode input acts as a three-state selector. The states are SUM, INDEP and MAC, and code 3 behaves as SUM. A transition takes effect at the next enabled clock edge. The accumulator only changes in MAC. A clear flag travels with a sample down the pipeline, and when that sample reaches the accumulator the accumulator loads the sample's total in place of adding it. One clock enable advances every register in the slice. A valid flag follows each sample so that out_valid marks the sample's result.

Top module: `dsp_slice`

## Requirements
- R1: In mode 0 (SUM) and mode 3, result_out is the sign-extended sum of the four signed lane products. The sum is 38 bits wide for 18-bit operands and does not overflow, even when every operand is the most negative or the most positive value.
- R2: Lane i of prod_out (bits 36*i+35 down to 36*i) holds the signed product of data lane i and coefficient lane i in every mode. In mode 1 (INDEP), result_out is zero.
- R3: In mode 2 (MAC), each valid sample reaching the output stage adds its total to the accumulator. A sample that entered with clr high loads its total in place of adding it. Edges without a valid sample leave the accumulator unchanged.
- R4: With pipe_en low, the result and out_valid of a sample captured at edge k appear after edge k+1. With pipe_en high they appear after edge k+2, one edge later. out_valid stays low before that edge.
- R5: With a bank's chain select low, each operand register of that bank loads its own lane of data_in or coef_in, and the serial input is ignored.
- R6: With data_chain_sel high, data register 0 loads data_shift_in and register i loads register i-1 at each enabled edge. The coefficient bank can still be loaded in parallel at the same time.
- R7: With coef_chain_sel high, the coefficient bank shifts from coef_shift_in in the same way. Both banks may shift at once.
- R8: data_casc_out and coef_casc_out always show the last register (lane 3) of their bank.
- R9: While en is low, no register changes: result_out, out_valid, prod_out and the cascade outputs hold.
- R10: Reset (rst_n low) clears every operand, pipeline, accumulator and output register, so out_valid and result_out read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Clock enable for every register |
| clr | input | 1 | Marks the sample that restarts the accumulation |
| in_valid | input | 1 | A sample is presented this cycle |
| pipe_en | input | 1 | Enables the register between multipliers and adders |
| data_chain_sel | input | 1 | 1 = data bank shifts, 0 = parallel load |
| coef_chain_sel | input | 1 | 1 = coefficient bank shifts, 0 = parallel load |
| mode | input | 2 | 0 SUM, 1 INDEP, 2 MAC, 3 as SUM |
| data_in | input | 72 | Parallel data operands, lane i at bits 18*i+17:18*i |
| coef_in | input | 72 | Parallel coefficient operands, same lane layout |
| data_shift_in | input | 18 | Serial input to data register 0 |
| coef_shift_in | input | 18 | Serial input to coefficient register 0 |
| data_casc_out | output | 18 | Last data register |
| coef_casc_out | output | 18 | Last coefficient register |
| prod_out | output | 144 | Registered lane products, 36 bits each |
| result_out | output | 48 | Sum, accumulation or zero, by mode |
| out_valid | output | 1 | result_out belongs to a valid sample |

## Verification
The hardest case is swapping coefficients while data streams through the tap line. The stimulus has to put a known value into every data tap, and then change the parallel coefficients on exactly the edge on which a new serial sample enters. The bench shifts a counting sequence into the data bank. It predicts each tap from the position of the sample in that sequence, replaces the coefficients on one chosen shift, and checks that the total just before the swap and the total just after it use the old and the new coefficient sets. Back-to-back accumulation with clear on the first sample is driven one sample per cycle, so that consecutive totals reach the accumulator on consecutive edges.

// File: rtl/dsp_slice_pkg.sv
package dsp_slice_pkg;
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        MODE_SUM   = 2'd0,
        MODE_INDEP = 2'd1,
        MODE_MAC   = 2'd2,
        MODE_ALT   = 2'd3
    } slice_mode_e;
endpackage

// File: rtl/dsp_tap_bank.sv
module dsp_tap_bank #(
    parameter int W = 18,
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           chain_sel,
    input  logic [N*W-1:0] par_in,
    input  logic [W-1:0]   shift_in,
    output logic [N*W-1:0] taps,
    output logic [W-1:0]   casc_out
);
    logic [W-1:0] stage [N];

    for (genvar i = 0; i < N; i++) begin : g_tap
        logic [W-1:0] chain_src;
        if (i == 0) begin : g_head
            assign chain_src = shift_in;
        end else begin : g_link
            assign chain_src = stage[i-1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                stage[i] <= '0;
            else if (en)
                stage[i] <= chain_sel ? chain_src : par_in[i*W +: W];
        end

        assign taps[i*W +: W] = stage[i];
    end

    assign casc_out = stage[N-1];
endmodule

// File: rtl/dsp_mult_stage.sv
module dsp_mult_stage #(
    parameter int W = 18,
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pipe_en,
    input  logic [N*W-1:0]   a_flat,
    input  logic [N*W-1:0]   b_flat,
    input  logic             vld_in,
    input  logic             clr_in,
    output logic [N*2*W-1:0] prod_flat,
    output logic             vld_out,
    output logic             clr_out
);
    localparam int PW = 2 * W;

    logic [N*PW-1:0] raw;
    logic [N*PW-1:0] raw_q;
    logic            vld_q;
    logic            clr_q;

    for (genvar i = 0; i < N; i++) begin : g_mul
        logic signed [W-1:0]  op_a;
        logic signed [W-1:0]  op_b;
        logic signed [PW-1:0] pr;
        assign op_a = a_flat[i*W +: W];
        assign op_b = b_flat[i*W +: W];
        assign pr   = PW'(op_a) * PW'(op_b);
        assign raw[i*PW +: PW] = pr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
            vld_q <= 1'b0;
            clr_q <= 1'b0;
        end else if (en) begin
            raw_q <= raw;
            vld_q <= vld_in;
            clr_q <= clr_in;
        end
    end

    assign prod_flat = pipe_en ? raw_q : raw;
    assign vld_out   = pipe_en ? vld_q : vld_in;
    assign clr_out   = pipe_en ? clr_q : clr_in;
endmodule

// File: rtl/dsp_adder_tree.sv
module dsp_adder_tree #(
    parameter int PW = 36,
    parameter int N  = 4
) (
    input  logic [N*PW-1:0]     prod_flat,
    output logic signed [PW+1:0] total
);
    localparam int HALF = N / 2;

    logic signed [PW:0] level1 [HALF];

    for (genvar j = 0; j < HALF; j++) begin : g_pair
        logic signed [PW-1:0] lo;
        logic signed [PW-1:0] hi;
        assign lo = prod_flat[(2*j)*PW +: PW];
        assign hi = prod_flat[(2*j+1)*PW +: PW];
        assign level1[j] = (PW+1)'(lo) + (PW+1)'(hi);
    end

    assign total = (PW+2)'(level1[0]) + (PW+2)'(level1[1]);
endmodule

// File: rtl/dsp_slice.sv
module dsp_slice
    import dsp_slice_pkg::*;
#(
    parameter int W     = 18,
    parameter int ACC_W = 48
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   clr,
    input  logic                   in_valid,
    input  logic                   pipe_en,
    input  logic                   data_chain_sel,
    input  logic                   coef_chain_sel,
    input  logic [1:0]             mode,
    input  logic [LANES*W-1:0]     data_in,
    input  logic [LANES*W-1:0]     coef_in,
    input  logic [W-1:0]           data_shift_in,
    input  logic [W-1:0]           coef_shift_in,
    output logic [W-1:0]           data_casc_out,
    output logic [W-1:0]           coef_casc_out,
    output logic [LANES*2*W-1:0]   prod_out,
    output logic [ACC_W-1:0]       result_out,
    output logic                   out_valid
);
    localparam int PW = 2 * W;
    localparam int SW = PW + 2;

    logic [LANES*W-1:0]  data_tap_q;
    logic [LANES*W-1:0]  coef_tap_q;
    logic                vin_q;
    logic                cin_q;
    logic [LANES*PW-1:0] prod_s;
    logic                vld_s;
    logic                clr_s;
    logic signed [SW-1:0] total;
    logic [ACC_W-1:0]    total_ext;
    logic [ACC_W-1:0]    acc_q;
    logic [ACC_W-1:0]    acc_next;
    logic [ACC_W-1:0]    result_next;
    slice_mode_e         mode_e;

    dsp_tap_bank #(.W(W), .N(LANES)) u_data_bank (
        .clk(clk), .rst_n(rst_n), .en(en), .chain_sel(data_chain_sel),
        .par_in(data_in), .shift_in(data_shift_in),
        .taps(data_tap_q), .casc_out(data_casc_out)
    );

    dsp_tap_bank #(.W(W), .N(LANES)) u_coef_bank (
        .clk(clk), .rst_n(rst_n), .en(en), .chain_sel(coef_chain_sel),
        .par_in(coef_in), .shift_in(coef_shift_in),
        .taps(coef_tap_q), .casc_out(coef_casc_out)
    );

    // Sample tags travel alongside the operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vin_q <= 1'b0;
            cin_q <= 1'b0;
        end else if (en) begin
            vin_q <= in_valid;
            cin_q <= clr & in_valid;
        end
    end

    dsp_mult_stage #(.W(W), .N(LANES)) u_mult (
        .clk(clk), .rst_n(rst_n), .en(en), .pipe_en(pipe_en),
        .a_flat(data_tap_q), .b_flat(coef_tap_q),
        .vld_in(vin_q), .clr_in(cin_q),
        .prod_flat(prod_s), .vld_out(vld_s), .clr_out(clr_s)
    );

    dsp_adder_tree #(.PW(PW), .N(LANES)) u_tree (
        .prod_flat(prod_s), .total(total)
    );

    assign total_ext = ACC_W'(total);
    assign mode_e    = slice_mode_e'(mode);

    always_comb begin
        acc_next = acc_q;
        if (vld_s)
            acc_next = clr_s ? total_ext : acc_q + total_ext;
    end

    always_comb begin
        unique case (mode_e)
            MODE_SUM,
            MODE_ALT:   result_next = total_ext;
            MODE_INDEP: result_next = '0;
            MODE_MAC:   result_next = acc_next;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            result_out <= '0;
            prod_out   <= '0;
            out_valid  <= 1'b0;
        end else if (en) begin
            if (mode_e == MODE_MAC)
                acc_q <= acc_next;
            result_out <= result_next;
            prod_out   <= prod_s;
            out_valid  <= vld_s;
        end
    end
endmodule

// File: rtl/dsp_slice_chk.sv
module dsp_slice_chk
    import dsp_slice_pkg::*;
#(
    parameter int W     = 18,
    parameter int ACC_W = 48
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic                 pipe_en,
    input logic                 data_chain_sel,
    input logic                 coef_chain_sel,
    input logic [1:0]           mode,
    input logic [LANES*W-1:0]   data_in,
    input logic [LANES*W-1:0]   data_tap_q,
    input logic [LANES*W-1:0]   coef_tap_q,
    input logic                 vin_q,
    input logic [ACC_W-1:0]     result_out,
    input logic                 out_valid,
    input logic [W-1:0]         data_casc_out,
    input logic [LANES*2*W-1:0] prod_out
);
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(result_out) && $stable(out_valid) && $stable(prod_out)
                && $stable(data_casc_out));

    assert_data_chain_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        en && data_chain_sel |=> data_tap_q[2*W-1:W] == $past(data_tap_q[W-1:0]));

    assert_coef_chain_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en && coef_chain_sel |=> coef_tap_q[LANES*W-1:(LANES-1)*W]
                                 == $past(coef_tap_q[(LANES-1)*W-1:(LANES-2)*W]));

    assert_parallel_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en && !data_chain_sel |=> data_tap_q == $past(data_in));

    assert_direct_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en && !pipe_en && vin_q |=> out_valid);

    assert_indep_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en && mode == MODE_INDEP |=> result_out == '0);
endmodule

bind dsp_slice dsp_slice_chk #(.W(W), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .pipe_en(pipe_en),
    .data_chain_sel(data_chain_sel), .coef_chain_sel(coef_chain_sel),
    .mode(mode), .data_in(data_in), .data_tap_q(data_tap_q),
    .coef_tap_q(coef_tap_q), .vin_q(vin_q), .result_out(result_out),
    .out_valid(out_valid), .data_casc_out(data_casc_out), .prod_out(prod_out)
);

// File: tb/dsp_slice_bench.sv
module dsp_slice_bench;
    localparam int W = 18;
    localparam int N = 4;
    localparam int A = 48;
    localparam int NV = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1, clr = 1'b0, in_valid = 1'b0, pipe_en = 1'b0;
    logic data_chain_sel = 1'b0, coef_chain_sel = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [N*W-1:0] data_in = '0, coef_in = '0;
    logic [W-1:0] data_shift_in = '0, coef_shift_in = '0;
    logic [W-1:0] data_casc_out, coef_casc_out;
    logic [N*2*W-1:0] prod_out;
    logic [A-1:0] result_out;
    logic out_valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dsp_slice u_dsp_slice (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .in_valid(in_valid),
        .pipe_en(pipe_en), .data_chain_sel(data_chain_sel),
        .coef_chain_sel(coef_chain_sel), .mode(mode), .data_in(data_in),
        .coef_in(coef_in), .data_shift_in(data_shift_in),
        .coef_shift_in(coef_shift_in), .data_casc_out(data_casc_out),
        .coef_casc_out(coef_casc_out), .prod_out(prod_out),
        .result_out(result_out), .out_valid(out_valid)
    );

    // Stimulus and expected totals of the four lane products
    localparam logic signed [W-1:0] VD [NV][N] = '{
        '{18'sd1, 18'sd2, 18'sd3, 18'sd4},
        '{-18'sd1, -18'sd2, -18'sd3, -18'sd4},
        '{18'sd100, -18'sd200, 18'sd300, -18'sd400},
        '{18'h1FFFF, 18'h1FFFF, 18'h1FFFF, 18'h1FFFF},
        '{18'h20000, 18'h20000, 18'h20000, 18'h20000}
    };
    localparam logic signed [W-1:0] VC [NV][N] = '{
        '{18'sd5, 18'sd6, 18'sd7, 18'sd8},
        '{18'sd1, 18'sd1, 18'sd1, 18'sd1},
        '{-18'sd3, 18'sd5, 18'sd7, -18'sd9},
        '{18'h1FFFF, 18'h1FFFF, 18'h1FFFF, 18'h1FFFF},
        '{18'h20000, 18'h20000, 18'h20000, 18'h20000}
    };
    localparam logic signed [63:0] VX [NV] = '{
        64'sd70, -64'sd10, 64'sd4400, 64'sd68718428164, 64'sd68719476736
    };

    task automatic check(input string req, input logic signed [63:0] act,
                         input logic signed [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic signed [63:0] res();
        return 64'($signed(result_out));
    endfunction

    task automatic load_vec(input int v);
        for (int i = 0; i < N; i++) begin
            data_in[i*W +: W] = VD[v][i];
            coef_in[i*W +: W] = VC[v][i];
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        check("R10 valid", 64'(out_valid), 0);
        check("R10 result", res(), 0);
        check("R10 cascade", 64'(data_casc_out), 0);

        // R1/R4/R5: table of vectors, SUM mode, shift inputs driven with junk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            load_vec(v);
            data_shift_in = 18'h15A5A;
            coef_shift_in = 18'h0F0F0;
            mode = (v == 2) ? 2'd3 : 2'd0;
            in_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check("R1 R5 total", res(), VX[v]);
            check("R4 valid", 64'(out_valid), 1);
            idle(2);
        end

        // R2: independent mode
        @(negedge clk);
        mode = 2'd1;
        load_vec(0);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++)
            check("R2 lane", 64'($signed(prod_out[i*2*W +: 2*W])),
                  64'(VD[0][i] * VC[0][i]));
        check("R2 result zero", res(), 0);
        idle(2);

        // R4: pipelined latency
        mode = 2'd0;
        pipe_en = 1'b1;
        load_vec(2);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R4 pipe early valid", 64'(out_valid), 0);
        @(posedge clk);
        @(negedge clk);
        check("R4 pipe valid", 64'(out_valid), 1);
        check("R4 pipe total", res(), 4400);
        pipe_en = 1'b0;
        idle(3);

        // R3: accumulate back-to-back, clear on first sample
        mode = 2'd2;
        load_vec(0);
        clr = 1'b1;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
        load_vec(1);
        @(posedge clk);
        @(negedge clk);
        check("R3 clear load", res(), 70);
        load_vec(2);
        @(posedge clk);
        @(negedge clk);
        check("R3 accumulate", res(), 60);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R3 accumulate", res(), 4460);
        @(posedge clk);
        @(negedge clk);
        check("R3 hold no valid", res(), 4460);

        // R9: enable low freezes everything
        en = 1'b0;
        load_vec(3);
        in_valid = 1'b1;
        clr = 1'b1;
        idle(3);
        check("R9 result hold", res(), 4460);
        check("R9 valid hold", 64'(out_valid), 0);
        in_valid = 1'b0;
        clr = 1'b0;
        en = 1'b1;
        mode = 2'd0;
        idle(2);

        // R6/R8: data taps shift, coefficients parallel then swapped
        data_chain_sel = 1'b1;
        for (int i = 0; i < N; i++) coef_in[i*W +: W] = 18'(10 ** i);
        for (int k = 1; k <= 5; k++) begin
            data_shift_in = 18'(k);
            @(posedge clk);
            @(negedge clk);
        end
        check("R6 taps 4321", res(), 1234);
        check("R8 data cascade", 64'(data_casc_out), 2);
        data_shift_in = 18'd6;
        for (int i = 0; i < N; i++) coef_in[i*W +: W] = 18'd1;
        @(posedge clk);
        @(negedge clk);
        check("R6 before swap", res(), 2345);
        data_shift_in = 18'd7;
        @(posedge clk);
        @(negedge clk);
        check("R6 after swap", res(), 18);

        // R7/R8: both banks shift
        coef_chain_sel = 1'b1;
        data_shift_in = 18'd2;
        coef_shift_in = 18'd3;
        idle(5);
        check("R7 both chains", res(), 24);
        check("R8 coef cascade", 64'(coef_casc_out), 3);
        check("R8 data cascade", 64'(data_casc_out), 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule